// File: doc/BRIEF.md
# Audio Converter Clock Chain

This block produces the three clocks an audio ADC or DAC needs: a master clock, a bit clock and a frame (left/right) clock. They come from three chained divider stages. The master stage counts cycles of the reference clock. The bit stage counts rising edges of the master clock, and the frame stage counts rising edges of the bit clock. Everything runs in the single reference clock domain. A downstream stage advances only in the reference cycle in which its upstream stage rises, so all clock edges line up on reference cycle boundaries.

Control is a requested sample rate in hertz plus start and stop pulses. On start, the rate is first limited to a configured window. A shared iterative divider then computes the master divisor, and reuses the same hardware to compute the sample rate that this divisor actually gives. The stages are then brought up in a fixed order: the external clock drivers are enabled (active low), then the frame stage, the bit stage and the master stage are enabled one cycle apart. An optional aligned start lengthens the first frame period by a count derived from the bit divisor. A stop pulse resets all stages at once and disables the drivers.

Top module: `audio_clk_chain`

## Requirements
- R1: After reset, mclk, bclk, lrclk and running are low, drv_en_n is high and actual_rate is 0.
- R2: The master divisor M is REF_HZ / (R × BIT_DIV × FRAME_DIV), rounded down and never below 2. R is the clamped rate. The mclk period is M reference cycles, and mclk is high for the first floor(M/2) of them.
- R3: The rate sampled on a start pulse is first limited to the range [RATE_MIN, RATE_MAX]. A request below the range acts as RATE_MIN, and a request above it acts as RATE_MAX.
- R4: Every bclk rising edge falls in the same cycle as an mclk rising edge, and the bclk period is BIT_DIV mclk periods. Every lrclk rising edge falls in the same cycle as a bclk rising edge, and after the first frame the lrclk period is FRAME_DIV bclk periods.
- R5: Start-up enables the frame stage, then the bit stage one cycle later, then the master stage one cycle after that. The first rising edges of mclk, bclk and lrclk all occur in the same cycle.
- R6: drv_en_n goes low before the first clock edge and stays low for as long as any clock output can be high.
- R7: If align_start is 1 when start is sampled, the first lrclk period is FRAME_DIV + S bclk periods. S = max(0, (BIT_DIV/4 − 2) × 10 + 6) + BIT_DIV/2, which is 10 for BIT_DIV = 8. If align_start is 0, the first lrclk period is FRAME_DIV bclk periods.
- R8: When running rises, actual_rate holds REF_HZ / (M × BIT_DIV × FRAME_DIV), rounded down.
- R9: A start pulse while the block is not idle is ignored. The divisor, the alignment choice and actual_rate all keep their values.
- R10: A stop pulse in any state returns the block to idle in the next cycle, with all three clocks low, drv_en_n high and running low. If start and stop arrive in the same cycle, stop wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all logic and all divider stages run on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to compute divisors and start the clocks |
| stop | input | 1 | One-cycle request to reset all stages and go idle |
| align_start | input | 1 | Sampled with start; 1 selects the stretched first frame |
| rate_hz | input | RATE_W | Requested sample rate in hertz, sampled with start |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame (left/right) clock |
| drv_en_n | output | 1 | Active-low enable for the external clock drivers |
| running | output | 1 | High once all three stages are enabled |
| actual_rate | output | 32 | Sample rate that the loaded divisor actually produces, in hertz |

## Verification
Two control functions can meet in a single cycle: a start request and a stop request. There is also a start that arrives while a previous start is still being sequenced or is already running. The bench raises start and stop on the same edge while the block is idle, and expects the block to stay idle with the drivers off for hundreds of cycles. It also issues a stop a few cycles into the divisor calculation, and a second start with a different rate while the clocks run. In the running case it judges the result by measuring that the mclk period and actual_rate still match the first request.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CALCM = 3'd1,
        ST_CALCR = 3'd2,
        ST_LOAD  = 3'd3,
        ST_ENF   = 3'd4,
        ST_ENB   = 3'd5,
        ST_ENM   = 3'd6,
        ST_RUN   = 3'd7
    } seq_state_e;

    // Extra bit-clock events added to the first frame of an aligned start.
    function automatic int lead_in(input int bdiv);
        int base;
        base = ((bdiv / 4) >= 2) ? (((bdiv / 4) - 2) * 10 + 6) : 0;
        return base + bdiv / 2;
    endfunction

endpackage

// File: rtl/acc_divider.sv
module acc_divider #(
    parameter int          DW  = 32,
    parameter int unsigned NUM = 100_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [DW-1:0] quo
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [DW-1:0] NUMV = DW'(NUM);

    typedef struct packed {
        logic [DW:0]   rem;
        logic [DW-1:0] q;
        logic [DW-1:0] d;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } div_t;

    div_t s_q, s_d;
    logic [DW:0] trial;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        trial    = {s_q.rem[DW-1:0], s_q.q[DW-1]};
        if (go) begin
            s_d.rem  = '0;
            s_d.q    = NUMV;
            s_d.d    = den;
            s_d.cnt  = CW'(DW);
            s_d.busy = 1'b1;
        end else if (s_q.busy) begin
            if (trial >= {1'b0, s_q.d}) begin
                s_d.rem = trial - {1'b0, s_q.d};
                s_d.q   = {s_q.q[DW-2:0], 1'b1};
            end else begin
                s_d.rem = trial;
                s_d.q   = {s_q.q[DW-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CW'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done = s_q.done;
    assign quo  = s_q.q;

    // R8: a zero denominator would make the rate results meaningless
    a_r8_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (den != '0));

    // R8: a result is only announced after an iteration run
    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(s_q.busy));

endmodule

// File: rtl/acc_stage.sv
module acc_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         evt,
    input  logic [W-1:0] div_first,
    input  logic [W-1:0] div_norm,
    output logic         clk_o,
    output logic         rise_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] per;
        logic         first;
        logic         o;
    } stage_t;

    stage_t s_q, s_d;
    logic [W-1:0] pick;

    always_comb begin
        s_d    = s_q;
        pick   = s_q.first ? div_first : div_norm;
        rise_o = en && evt && (s_q.cnt == '0);
        if (!en) begin
            s_d.cnt   = '0;
            s_d.per   = '0;
            s_d.first = 1'b1;
            s_d.o     = 1'b0;
        end else if (evt) begin
            if (s_q.cnt == '0) begin
                s_d.cnt   = pick - 1'b1;
                s_d.per   = pick;
                s_d.first = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
            s_d.o = (s_d.cnt >= (s_d.per - (s_d.per >> 1)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, per: '0, first: 1'b1, o: 1'b0};
        else        s_q <= s_d;
    end

    assign clk_o = s_q.o;

    // R2: the down-counter never escapes the loaded period
    a_r2_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.per != '0) |-> (s_q.cnt < s_q.per));

    // R10: a disabled stage is quiet in the following cycle
    a_r10_stage_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !clk_o);

endmodule

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
#(
    parameter int RATE_W   = 17,
    parameter int RATE_MIN = 8000,
    parameter int RATE_MAX = 96000,
    parameter int MDIV_W   = 16,
    parameter int BF       = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              align_in,
    input  logic [RATE_W-1:0] rate_in,
    input  logic              div_done,
    input  logic [31:0]       div_quo,
    output logic              div_go,
    output logic [31:0]       div_den,
    output logic [MDIV_W-1:0] mdiv,
    output logic              align,
    output logic [31:0]       actual,
    output logic              en_f,
    output logic              en_b,
    output logic              en_m,
    output logic              drv_n,
    output logic              running
);
    localparam logic [RATE_W-1:0] MIN_R    = RATE_W'(RATE_MIN);
    localparam logic [RATE_W-1:0] MAX_R    = RATE_W'(RATE_MAX);
    localparam logic [MDIV_W-1:0] MDIV_MAX = {MDIV_W{1'b1}};
    localparam logic [31:0]       BF32     = 32'(BF);

    typedef struct packed {
        seq_state_e        st;
        logic [RATE_W-1:0] rate;
        logic              align;
        logic [MDIV_W-1:0] mdiv;
        logic [31:0]       actual;
        logic              en_f;
        logic              en_b;
        logic              en_m;
        logic              drv_n;
    } seq_t;

    seq_t s_q, s_d;
    logic [RATE_W-1:0] rate_cl;
    logic [MDIV_W-1:0] msat;

    always_comb begin
        if (rate_in < MIN_R)      rate_cl = MIN_R;
        else if (rate_in > MAX_R) rate_cl = MAX_R;
        else                      rate_cl = rate_in;

        if (div_quo < 32'd2)               msat = MDIV_W'(2);
        else if (div_quo > 32'(MDIV_MAX))  msat = MDIV_MAX;
        else                               msat = div_quo[MDIV_W-1:0];
    end

    always_comb begin
        s_d     = s_q;
        div_go  = 1'b0;
        div_den = 32'(rate_cl) * BF32;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.rate  = rate_cl;
                    s_d.align = align_in;
                    s_d.st    = ST_CALCM;
                    div_go    = 1'b1;
                end
            end
            ST_CALCM: begin
                div_den = 32'(msat) * BF32;
                if (div_done) begin
                    s_d.mdiv = msat;
                    s_d.st   = ST_CALCR;
                    div_go   = 1'b1;
                end
            end
            ST_CALCR: begin
                if (div_done) begin
                    s_d.actual = div_quo;
                    s_d.st     = ST_LOAD;
                end
            end
            ST_LOAD: begin
                s_d.drv_n = 1'b0;
                s_d.st    = ST_ENF;
            end
            ST_ENF: begin
                s_d.en_f = 1'b1;
                s_d.st   = ST_ENB;
            end
            ST_ENB: begin
                s_d.en_b = 1'b1;
                s_d.st   = ST_ENM;
            end
            ST_ENM: begin
                s_d.en_m = 1'b1;
                s_d.st   = ST_RUN;
            end
            default: ;
        endcase
        if (stop) begin
            s_d.st    = ST_IDLE;
            s_d.en_f  = 1'b0;
            s_d.en_b  = 1'b0;
            s_d.en_m  = 1'b0;
            s_d.drv_n = 1'b1;
            div_go    = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, rate: MIN_R, align: 1'b0, mdiv: MDIV_W'(2),
                     actual: '0, en_f: 1'b0, en_b: 1'b0, en_m: 1'b0, drv_n: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign mdiv    = s_q.mdiv;
    assign align   = s_q.align;
    assign actual  = s_q.actual;
    assign en_f    = s_q.en_f;
    assign en_b    = s_q.en_b;
    assign en_m    = s_q.en_m;
    assign drv_n   = s_q.drv_n;
    assign running = (s_q.st == ST_RUN);

    // R5: master stage only runs with both downstream stages already on
    a_r5_enable_nesting: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.en_m |-> (s_q.en_b && s_q.en_f));

    // R5: bit stage comes up one cycle after the frame stage
    a_r5_bit_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.en_b) |-> $past(s_q.en_f));

    // R3: a sequence in progress always carries a rate inside the window
    a_r3_rate_window: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |-> (s_q.rate >= MIN_R && s_q.rate <= MAX_R));

    // R9: a start outside idle leaves the captured settings untouched
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE && start) |=> ($stable(s_q.rate) && $stable(s_q.align) && $stable(s_q.mdiv)));

    // R6: drivers are enabled before any stage is enabled
    a_r6_drivers_first: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.en_f |-> !s_q.drv_n);

endmodule

// File: rtl/audio_clk_chain.sv
module audio_clk_chain
    import acc_pkg::*;
#(
    parameter int unsigned REF_HZ    = 100_000_000,
    parameter int          RATE_W    = 17,
    parameter int          RATE_MIN  = 8000,
    parameter int          RATE_MAX  = 96000,
    parameter int          MDIV_W    = 16,
    parameter int          BIT_DIV   = 8,
    parameter int          FRAME_DIV = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic              align_start,
    input  logic [RATE_W-1:0] rate_hz,
    output logic              mclk,
    output logic              bclk,
    output logic              lrclk,
    output logic              drv_en_n,
    output logic              running,
    output logic [31:0]       actual_rate
);
    localparam int BF      = BIT_DIV * FRAME_DIV;
    localparam int STRETCH = lead_in(BIT_DIV);
    localparam int BW      = $clog2(BIT_DIV + 1);
    localparam int FW      = $clog2(FRAME_DIV + STRETCH + 1);
    localparam logic [BW-1:0] BDIV_V  = BW'(BIT_DIV);
    localparam logic [FW-1:0] FDIV_V  = FW'(FRAME_DIV);
    localparam logic [FW-1:0] FLONG_V = FW'(FRAME_DIV + STRETCH);

    logic              div_go, div_done;
    logic [31:0]       div_den, div_quo;
    logic [MDIV_W-1:0] mdiv;
    logic              align_q;
    logic              en_f, en_b, en_m;
    logic              run_f, run_b, run_m;
    logic              m_rise, b_rise, f_rise;
    logic [FW-1:0]     f_first;

    acc_seq #(
        .RATE_W  (RATE_W),
        .RATE_MIN(RATE_MIN),
        .RATE_MAX(RATE_MAX),
        .MDIV_W  (MDIV_W),
        .BF      (BF)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .stop    (stop),
        .align_in(align_start),
        .rate_in (rate_hz),
        .div_done(div_done),
        .div_quo (div_quo),
        .div_go  (div_go),
        .div_den (div_den),
        .mdiv    (mdiv),
        .align   (align_q),
        .actual  (actual_rate),
        .en_f    (en_f),
        .en_b    (en_b),
        .en_m    (en_m),
        .drv_n   (drv_en_n),
        .running (running)
    );

    acc_divider #(
        .DW (32),
        .NUM(REF_HZ)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .go   (div_go),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    // A stop clears the stages on the same edge that it is sampled
    assign run_m   = en_m && !stop;
    assign run_b   = en_b && !stop;
    assign run_f   = en_f && !stop;
    assign f_first = align_q ? FLONG_V : FDIV_V;

    acc_stage #(.W(MDIV_W)) u_mstage (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_m),
        .evt      (1'b1),
        .div_first(mdiv),
        .div_norm (mdiv),
        .clk_o    (mclk),
        .rise_o   (m_rise)
    );

    acc_stage #(.W(BW)) u_bstage (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_b),
        .evt      (m_rise),
        .div_first(BDIV_V),
        .div_norm (BDIV_V),
        .clk_o    (bclk),
        .rise_o   (b_rise)
    );

    acc_stage #(.W(FW)) u_fstage (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_f),
        .evt      (b_rise),
        .div_first(f_first),
        .div_norm (FDIV_V),
        .clk_o    (lrclk),
        .rise_o   (f_rise)
    );

    // R4: bit clock rises only together with the master clock
    a_r4_bit_on_master: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> $rose(mclk));

    // R4: frame clock rises only together with the bit clock
    a_r4_frame_on_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lrclk) |-> $rose(bclk));

    // R6: no clock is high while the drivers are disabled
    a_r6_driver_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mclk || bclk || lrclk) |-> !drv_en_n);

    // R10: stop silences everything by the next cycle
    a_r10_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!mclk && !bclk && !lrclk && drv_en_n && !running));

    // R5: the frame stage's rise event can only follow a bit stage rise
    a_r5_frame_event_chain: assert property (@(posedge clk) disable iff (!rst_n)
        f_rise |-> (b_rise && m_rise));

endmodule

// File: tb/audio_clk_chain_tb.sv
module audio_clk_chain_tb;
    localparam int REF  = 100_000_000;
    localparam int RMIN = 8000;
    localparam int RMAX = 96000;
    localparam int BD   = 8;
    localparam int FD   = 32;
    localparam int SX   = 10;   // R7 stretch for BIT_DIV = 8: 0*10+6 + 4

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic        align_start = 1'b0;
    logic [16:0] rate_hz = '0;
    logic        mclk, bclk, lrclk, drv_en_n, running;
    logic [31:0] actual_rate;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    audio_clk_chain u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .stop       (stop),
        .align_start(align_start),
        .rate_hz    (rate_hz),
        .mclk       (mclk),
        .bclk       (bclk),
        .lrclk      (lrclk),
        .drv_en_n   (drv_en_n),
        .running    (running),
        .actual_rate(actual_rate)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_m(input int r);
        int cl, m;
        cl = (r < RMIN) ? RMIN : ((r > RMAX) ? RMAX : r);
        m  = REF / (cl * BD * FD);
        if (m < 2) m = 2;
        return m;
    endfunction

    function automatic int exp_a(input int m);
        return REF / (m * BD * FD);
    endfunction

    task automatic pulse_start(input int r, input bit a);
        @(negedge clk);
        rate_hz     = 17'(r);
        align_start = a;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic test_reset();
        check(!mclk && !bclk && !lrclk, "R1 clocks low", {mclk, bclk, lrclk}, 0);
        check(drv_en_n && !running, "R1 drivers off", {drv_en_n, running}, 2);
        check(actual_rate == 0, "R1 actual_rate", actual_rate, 0);
    endtask

    task automatic run_case(input string name, input int r, input bit a);
        int m, ea, k, mi, bi, li, mh, bad_b, bad_l, bad_d, w, fexp;
        int mr[3];
        int br[3];
        int lr[3];
        bit pm, pb, pl, mrise, brise, lrise;
        m  = exp_m(r);
        ea = exp_a(m);
        pulse_start(r, a);
        w = 0;
        while (!mclk && w < 1000) begin
            @(negedge clk);
            w++;
        end
        check(mclk && bclk && lrclk, {name, " R5 first edges together"}, {mclk, bclk, lrclk}, 7);
        check(!drv_en_n, {name, " R6 drivers on at first edge"}, drv_en_n, 0);
        check(running, {name, " R5 running at first edge"}, running, 1);
        check(actual_rate == 32'(ea), {name, " R8 actual_rate"}, actual_rate, ea);
        mr[0] = 0; br[0] = 0; lr[0] = 0;
        mi = 1; bi = 1; li = 1; mh = 1;
        bad_b = 0; bad_l = 0; bad_d = 0;
        pm = 1'b1; pb = 1'b1; pl = 1'b1; k = 0;
        while (li < 3 && k < 100000) begin
            @(negedge clk);
            k++;
            mrise = mclk && !pm;
            brise = bclk && !pb;
            lrise = lrclk && !pl;
            if (mrise && mi < 3) begin mr[mi] = k; mi++; end
            if (brise && bi < 3) begin br[bi] = k; bi++; end
            if (lrise && li < 3) begin lr[li] = k; li++; end
            if (brise && !mrise) bad_b++;
            if (lrise && !brise) bad_l++;
            if ((mclk || bclk || lrclk) && drv_en_n) bad_d++;
            if (mi == 1 && mclk) mh++;
            pm = mclk; pb = bclk; pl = lrclk;
        end
        fexp = a ? (FD + SX) : FD;
        check(mr[1] - mr[0] == m, {name, " R2 mclk period"}, mr[1] - mr[0], m);
        check(mh == m / 2, {name, " R2 mclk high time"}, mh, m / 2);
        check(br[1] - br[0] == m * BD, {name, " R4 bclk period"}, br[1] - br[0], m * BD);
        check(lr[1] - lr[0] == m * BD * fexp, {name, " R7 first frame"}, lr[1] - lr[0], m * BD * fexp);
        check(lr[2] - lr[1] == m * BD * FD, {name, " R4 steady frame"}, lr[2] - lr[1], m * BD * FD);
        check(bad_b == 0 && bad_l == 0, {name, " R4 edge coincidence"}, bad_b + bad_l, 0);
        check(bad_d == 0, {name, " R6 drivers held on"}, bad_d, 0);
    endtask

    task automatic test_restart_ignored(input int first_rate);
        int m, w, r0, r1, pm;
        m = exp_m(first_rate);
        pulse_start(8000, 1'b0);
        repeat (100) @(negedge clk);
        r0 = -1; r1 = -1; pm = mclk; w = 0;
        while (r1 < 0 && w < 1000) begin
            @(negedge clk);
            w++;
            if (mclk && !pm) begin
                if (r0 < 0) r0 = w;
                else        r1 = w;
            end
            pm = mclk;
        end
        check(r1 - r0 == m, "R9 mclk period kept", r1 - r0, m);
        check(actual_rate == 32'(exp_a(m)), "R9 actual_rate kept", actual_rate, exp_a(m));
        check(running, "R9 still running", running, 1);
    endtask

    task automatic test_stop();
        int hi;
        pulse_stop();
        check(!mclk && !bclk && !lrclk, "R10 clocks low after stop", {mclk, bclk, lrclk}, 0);
        check(drv_en_n && !running, "R10 idle after stop", {drv_en_n, running}, 2);
        hi = 0;
        repeat (3000) begin
            @(negedge clk);
            if (mclk || bclk || lrclk || running) hi++;
        end
        check(hi == 0, "R10 stays quiet", hi, 0);
    endtask

    task automatic test_start_stop_same_cycle();
        int act;
        @(negedge clk);
        rate_hz = 17'd48000;
        start   = 1'b1;
        stop    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        stop  = 1'b0;
        act = 0;
        repeat (300) begin
            @(negedge clk);
            if (running || !drv_en_n || mclk) act++;
        end
        check(act == 0, "R10 stop wins over start", act, 0);
    endtask

    task automatic test_stop_during_calc();
        int act;
        pulse_start(48000, 1'b1);
        repeat (5) @(negedge clk);
        pulse_stop();
        act = 0;
        repeat (300) begin
            @(negedge clk);
            if (running || !drv_en_n || mclk) act++;
        end
        check(act == 0, "R10 stop during calculation", act, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        run_case("aligned 48k", 48000, 1'b1);
        test_restart_ignored(48000);
        test_stop();
        run_case("plain 48k", 48000, 1'b0);
        test_stop();
        test_start_stop_same_cycle();
        test_stop_during_calc();
        run_case("R3 floor clamp", 5000, 1'b0);
        test_stop();
        run_case("R3 ceiling clamp", 120000, 1'b1);
        test_stop();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule